// File: doc/BRIEF.md
# Thread Block Dispatcher

This block sits between a launch port driven by the host side and a small array of compute units. A launch gives the number of blocks in a grid and the thread count of each block. The dispatcher checks the launch. It then hands out block indices 0, 1, 2 and onward, in that order, one at a time. Each block goes to a compute unit that still has a free residency slot.

Each unit can hold up to `SLOTS_PER_UNIT` blocks at once. A block stays on the unit it was given to until that unit reports that the block is finished. Each finish report frees one slot, and the next block in sequence fills it. After every block has been handed out and every finish report has come back, the dispatcher raises a one-cycle grid-done pulse and returns to idle, ready for a new launch. Only one grid is in flight at a time.

Top module: `blk_dispatch`

## Requirements
- R1: After reset, `busy`, `grid_done`, `launch_error` and every bit of `issue_valid` are 0.
- R2: A launch seen while idle is rejected when the thread count exceeds `MAX_THREADS` (default 1024), when the thread count is 0, or when the block count is 0. On a rejection, `launch_error` is 1 for exactly the cycle after the launch, no block is offered, and `busy` stays 0.
- R3: An accepted launch of N blocks offers block indices on `issue_block` in the order 0, 1, ..., N-1. Each index is handed over exactly once, by a handshake in which `issue_valid[u]` and `issue_ready[u]` are both 1 at a clock edge.
- R4: A unit is offered a block only while it holds fewer than `SLOTS_PER_UNIT` resident blocks. A unit's occupancy never exceeds that limit. When every unit is full, no bit of `issue_valid` is set.
- R5: The offer goes to the lowest-numbered unit that has a free slot. Bit u of `issue_valid` stands for unit u.
- R6: At most one bit of `issue_valid` is set in any cycle. `issue_block` does not change until a handshake takes place, and the offer waits on its unit while that unit is not ready.
- R7: A pulse on `done_valid[u]` retires one resident block of unit u. The freed slot is offered the next block in sequence, starting the cycle after the pulse.
- R8: A pulse on `done_valid[u]` while unit u holds no block has no effect.
- R9: `busy` is 1 from the cycle after an accepted launch until the grid finishes. `grid_done` is a single-cycle pulse that appears once all N blocks have been handed over and all N completions have been received. In that same cycle `busy` returns to 0.
- R10: A launch presented while busy is ignored. It raises no error and does not change the block count of the running grid.
- R11: A launch with exactly `MAX_THREADS` threads per block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request strobe |
| launch_blocks | input | BLK_W | Number of blocks in the grid |
| launch_threads | input | THR_W | Threads per block |
| launch_error | output | 1 | One-cycle pulse when a launch is rejected |
| busy | output | 1 | A grid is in progress |
| issue_valid | output | NUM_UNITS | Per-unit block offer, at most one bit set |
| issue_ready | input | NUM_UNITS | Per-unit acceptance of the offer |
| issue_block | output | BLK_W | Index of the block on offer |
| done_valid | input | NUM_UNITS | Per-unit block completion pulse |
| grid_done | output | 1 | One-cycle pulse when the grid is finished |

## Verification
The bench aims at the following corner cases. Each is listed with the wrong behaviour a faulty design would show.

- Capacity edge: every slot in the array is filled. A design with an off-by-one capacity check would offer a ninth block.
- Refill after one completion: a design that refills by round-robin instead of by lowest free unit would send the freed slot's block to the wrong unit.
- Completion on an empty unit: if the occupancy counter underflowed, that unit would stop taking blocks and the grid would hang.
- Thread limit boundary (1024 accepted, 1025 rejected) and launches with zero blocks or zero threads: these expose wrong comparisons.
- Backpressure on the selected unit: a design that let the index move before the handshake would skip or repeat blocks.
- A second launch during a running grid: a design that accepted it would change the grid size, and the `grid_done` pulse would come early or late.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } disp_state_e;
endpackage

// File: rtl/unit_occ_tracker.sv
module unit_occ_tracker #(
    parameter int SLOTS = 2,
    parameter int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [OCC_W-1:0] occ,
    output logic             has_room
);
    logic [OCC_W-1:0] occ_d, occ_q;
    logic             dec_eff;

    always_comb begin
        // A completion on an empty unit is dropped.
        dec_eff = dec && (occ_q != '0);
        occ_d   = occ_q;
        if (inc && !dec_eff)      occ_d = occ_q + 1'b1;
        else if (!inc && dec_eff) occ_d = occ_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign occ      = occ_q;
    assign has_room = (32'(occ_q) < SLOTS);

    // R4
    occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occ_q) <= SLOTS);

    // R4
    inc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (32'(occ_q) < SLOTS));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && occ_q == '0) |=> occ_q == '0);
endmodule

// File: rtl/lowest_room_pick.sv
module lowest_room_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] room,
    output logic [N-1:0] pick
);
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (room[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    // R5
    pick_onehot_chk: assert final ($onehot0(pick));
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
    import blk_dispatch_pkg::*;
#(
    parameter int NUM_UNITS      = 4,
    parameter int SLOTS_PER_UNIT = 2,
    parameter int BLK_W          = 16,
    parameter int THR_W          = 11,
    parameter int MAX_THREADS    = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_valid,
    input  logic [BLK_W-1:0]     launch_blocks,
    input  logic [THR_W-1:0]     launch_threads,
    output logic                 launch_error,
    output logic                 busy,
    output logic [NUM_UNITS-1:0] issue_valid,
    input  logic [NUM_UNITS-1:0] issue_ready,
    output logic [BLK_W-1:0]     issue_block,
    input  logic [NUM_UNITS-1:0] done_valid,
    output logic                 grid_done
);
    localparam int OCC_W = $clog2(SLOTS_PER_UNIT + 1);

    typedef struct packed {
        disp_state_e      state;
        logic [BLK_W-1:0] total;
        logic [BLK_W-1:0] next_blk;
        logic             err;
        logic             done;
    } disp_regs_t;

    disp_regs_t d, q;

    logic [NUM_UNITS-1:0] room, pick, fire_vec, occupied;
    logic [OCC_W-1:0]     occ_w [NUM_UNITS];
    logic                 more, fire, all_empty, bad_launch;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_occ_tracker #(
            .SLOTS (SLOTS_PER_UNIT),
            .OCC_W (OCC_W)
        ) trk_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (fire_vec[u]),
            .dec      (done_valid[u]),
            .occ      (occ_w[u]),
            .has_room (room[u])
        );
        assign occupied[u] = (occ_w[u] != '0);
    end

    lowest_room_pick #(.N(NUM_UNITS)) pick_i (
        .room (room),
        .pick (pick)
    );

    always_comb begin
        more        = (q.state == ST_RUN) && (q.next_blk != q.total);
        issue_valid = more ? pick : '0;
        fire_vec    = issue_valid & issue_ready;
        fire        = |fire_vec;
        all_empty   = ~|occupied;
        bad_launch  = (launch_threads == '0) || (32'(launch_threads) > MAX_THREADS)
                      || (launch_blocks == '0);

        d      = q;
        d.err  = 1'b0;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (launch_valid) begin
                    if (bad_launch) begin
                        d.err = 1'b1;
                    end else begin
                        d.state    = ST_RUN;
                        d.total    = launch_blocks;
                        d.next_blk = '0;
                    end
                end
            end
            default: begin
                if (fire) d.next_blk = q.next_blk + 1'b1;
                if (!more && all_empty) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.total    <= '0;
            q.next_blk <= '0;
            q.err      <= 1'b0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign issue_block  = q.next_blk;
    assign busy         = (q.state == ST_RUN);
    assign launch_error = q.err;
    assign grid_done    = q.done;

    // R6
    one_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_valid));

    // R6
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|issue_valid && !(|(issue_valid & issue_ready))) |=> $stable(issue_block));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(issue_valid & issue_ready)) |=> issue_block == $past(issue_block) + 1'b1);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |=> !grid_done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> (!busy && issue_valid == '0));

    // R2
    err_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_error |-> (!busy && issue_valid == '0));

    // R10
    busy_launch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch_valid) |=> !launch_error);
endmodule

// File: tb/blk_dispatch_tb_top.sv
module blk_dispatch_tb_top;
    localparam int NU    = 4;
    localparam int SL    = 2;
    localparam int BW    = 16;
    localparam int TW    = 11;
    localparam int MAXT  = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic [BW-1:0] launch_blocks = '0;
    logic [TW-1:0] launch_threads = '0;
    logic          launch_error, busy, grid_done;
    logic [NU-1:0] issue_valid;
    logic [NU-1:0] issue_ready = '0;
    logic [BW-1:0] issue_block;
    logic [NU-1:0] done_valid = '0;

    int checks = 0, failures = 0;
    bit finished = 0;

    // bench model
    bit running = 0, exp_done = 0, exp_err = 0;
    int total = 0, exp_next = 0, issued = 0;
    int mocc [NU];

    always #2 clk = ~clk;

    blk_dispatch #(
        .NUM_UNITS(NU), .SLOTS_PER_UNIT(SL), .BLK_W(BW), .THR_W(TW), .MAX_THREADS(MAXT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_blocks(launch_blocks),
        .launch_threads(launch_threads), .launch_error(launch_error), .busy(busy),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_block(issue_block),
        .done_valid(done_valid), .grid_done(grid_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One sample point: compare ports to the model, then advance the model one edge.
    task automatic tick();
        logic [NU-1:0] exp_vec = '0;
        bit found = 0, empty = 1;
        int occ_old [NU];
        int next_old = exp_next;
        if (running && exp_next < total)
            for (int u = 0; u < NU; u++)
                if (!found && mocc[u] < SL) begin exp_vec[u] = 1'b1; found = 1; end
        chk(issue_valid == exp_vec, "R5/R4 offer target", int'(issue_valid), int'(exp_vec));
        if (exp_vec != '0) chk(int'(issue_block) == exp_next, "R3 block index", int'(issue_block), exp_next);
        chk(busy == running, "R9 busy", int'(busy), int'(running));
        chk(grid_done == exp_done, "R9 grid_done", int'(grid_done), int'(exp_done));
        chk(launch_error == exp_err, "R2 launch_error", int'(launch_error), int'(exp_err));
        for (int u = 0; u < NU; u++) begin
            occ_old[u] = mocc[u];
            if (mocc[u] != 0) empty = 0;
        end
        exp_done = 0;
        exp_err  = 0;
        for (int u = 0; u < NU; u++) begin
            if (done_valid[u] && occ_old[u] > 0) mocc[u]--;
            if (exp_vec[u] && issue_ready[u]) begin mocc[u]++; exp_next++; issued++; end
        end
        if (running && next_old == total && empty) begin
            running = 0;
            exp_done = 1;
        end else if (!running && launch_valid) begin
            if (launch_threads == 0 || int'(launch_threads) > MAXT || launch_blocks == 0) exp_err = 1;
            else begin running = 1; total = int'(launch_blocks); exp_next = 0; issued = 0; end
        end
        @(negedge clk);
    endtask

    task automatic do_launch(input int blocks, input int threads);
        launch_blocks  = BW'(blocks);
        launch_threads = TW'(threads);
        launch_valid   = 1'b1;
        tick();
        launch_valid   = 1'b0;
    endtask

    task automatic drain(input int total_exp, input string tag);
        for (int i = 0; i < 3000 && (running || exp_done); i++) begin
            done_valid = NU'($urandom);
            tick();
        end
        done_valid = '0;
        tick();
        chk(issued == total_exp, tag, issued, total_exp);
        chk(!busy, "R9 idle after grid", int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !grid_done && !launch_error && issue_valid == '0, "R1 reset outputs",
            int'({busy, grid_done, launch_error, issue_valid}), 0);
        tick();
    endtask

    task automatic t_reject();
        do_launch(5, 1025);
        chk(launch_error, "R2 over-limit rejected", int'(launch_error), 1);
        tick();
        chk(!launch_error, "R2 error one cycle", int'(launch_error), 0);
        do_launch(5, 0);
        tick();
        do_launch(0, 8);
        tick();
        chk(!busy && issue_valid == '0, "R2 nothing issued", int'(issue_valid), 0);
    endtask

    task automatic t_fill_refill();
        issue_ready = '1;
        do_launch(12, 1024);
        chk(busy, "R11 1024 threads accepted", int'(busy), 1);
        for (int i = 0; i < 10; i++) tick();
        chk(issue_valid == '0, "R4 all full no offer", int'(issue_valid), 0);
        done_valid = 4'b0100;
        tick();
        done_valid = '0;
        chk(issue_valid == 4'b0100, "R7 refill freed unit", int'(issue_valid), 4);
        tick();
        do_launch(3, 5);
        chk(!launch_error, "R10 no error while busy", int'(launch_error), 0);
        drain(12, "R10 grid size kept at 12");
    endtask

    task automatic t_backpressure();
        issue_ready = '0;
        do_launch(10, 32);
        done_valid = 4'b1000;
        tick();
        done_valid = '0;
        for (int i = 0; i < 3; i++) tick();
        chk(issue_valid == 4'b0001 && issue_block == 0, "R6 offer held", int'(issue_block), 0);
        issue_ready = '1;
        for (int i = 0; i < 10; i++) tick();
        chk(issue_valid == '0 && issued == 8, "R8 empty done ignored", issued, 8);
        drain(10, "R3 all blocks issued");
    endtask

    task automatic t_random();
        do_launch(40, 256);
        for (int i = 0; i < 3000 && running; i++) begin
            issue_ready = NU'($urandom);
            done_valid  = NU'($urandom);
            tick();
        end
        issue_ready = '1;
        drain(40, "R3 random grid complete");
    endtask

    initial begin
        for (int u = 0; u < NU; u++) mocc[u] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_fill_refill();
        t_backpressure();
        t_random();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule